// File: doc/BRIEF.md
# A32 Instruction Class Decoder

This block is one registered stage of an instruction decoder. It takes a 32-bit A32 instruction word together with a valid strobe and sorts the word into one of a few coarse classes. It also pulls out the condition code, the Rn, Rd and Rm register numbers and the pre-index, up and writeback bits. Later stages use the class to choose an operand path. Operand fetch, execution and memory access are left to those stages.

Classification runs as a short tree. The condition field first splits off the unconditional space. Bits 27-25 then pick out the data-processing and miscellaneous group. Inside that group, bits 7-4 are tested before the opcode bits, so that a word whose top half reads like a register move-not is sent to the extra load/store space when its low nibble says so. The signed-byte load with immediate offset is then identified within the extra load/store space. A word that matches no implemented class raises an unsupported flag. It never falls through to data-processing.

Top module: `a32_class_decoder`

## Requirements
- R1: While rst_ni is low, valid_o, unsup_o, the flags and all field outputs are 0, and class_o is 0 (unsupported).
- R2: Outputs change only on a rising edge of clk_i, one cycle after a word is presented. valid_o equals valid_i of the previous cycle.
- R3: Class codes: 0 unsupported, 1 register data-processing, 2 immediate data-processing, 3 extra load/store, 4 signed-byte load with immediate offset, 5 unconditional. unsup_o is 1 exactly when a valid word has class 0.
- R4: A word with bits 31-28 = 1111 gets class 5 whatever its other bits are.
- R5: A conditional word whose bits 27-26 are not 00 gets class 0.
- R6: In the 00x group with bit 25 = 1, the word gets class 2, unless bits 24-20 match 10xx0, in which case it gets class 0.
- R7: In the 00x group with bit 25 = 0, a word whose bits 7-4 are 1011 or match 11x1 gets class 3 or 4 when bits 24-20 do not match 0xx1x. It gets class 0 when they do match 0xx1x.
- R8: A class-3 candidate is promoted to class 4 when bits 6-5 = 10, bits 24-20 match xx1x1 and Rn (bits 19-16) is not 1111. A candidate with Rn = 1111 stays class 3.
- R9: With bit 25 = 0 and none of the patterns in R7, bits 7-4 = 1001 give class 0. Bits 24-20 matching 10xx0 also give class 0. Every other word gets class 1, including bits 7-4 = 0000 and the register-shifted forms (bit 7 = 0, bit 4 = 1).
- R10: For every class, cond_o = bits 31-28, rn_o = bits 19-16, rd_o = bits 15-12 and rm_o = bits 3-0.
- R11: pre_o, up_o and wback_o carry bits 24, 23 and 21 for classes 3 and 4, and are 0 for every other class.
- R12: Word E1F120D1 decodes as class 4 with Rd = 2, Rn = 1, Rm = 1, pre_o = up_o = wback_o = 1. It must not be treated as a move-not.
- R13: While valid_i is low, every data output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid |
| instr_i | input | 32 | A32 instruction word |
| valid_o | output | 1 | Registered valid |
| class_o | output | 3 | Class code (see R3) |
| unsup_o | output | 1 | Word matches no implemented class |
| cond_o | output | 4 | Condition field |
| rn_o | output | 4 | Rn field |
| rd_o | output | 4 | Rd field |
| rm_o | output | 4 | Rm field |
| pre_o | output | 1 | Pre-index bit, load/store classes only |
| up_o | output | 1 | Add-offset bit, load/store classes only |
| wback_o | output | 1 | Writeback bit, load/store classes only |

## Verification
The main target is E1F120D1 and its neighbours. A decoder that reads the opcode before bits 7-4 would report this word as register data-processing, and a plain register move-not with a zero low nibble checks the opposite mistake. The bench also covers the boundaries of the signed-byte load: Rn = 1111, the unprivileged 0xx1x opcode pattern and the halfword load, where a loose mask would promote or demote the class. It also covers the miscellaneous 10xx0 opcodes in both the register and the immediate branch, the multiply nibble 1001, the condition 1111, and a load/store word outside the group. A design that defaulted unmatched words to data-processing would fail on these. Hold behaviour while valid_i is low and flag gating for non-memory classes complete the set.

// File: rtl/a32_dec_pkg.sv
package a32_dec_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned OP1_W  = 5;
  localparam int unsigned OP2_W  = 4;
  localparam int unsigned CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_UNSUP     = 3'd0,
    CLS_DP_REG    = 3'd1,
    CLS_DP_IMM    = 3'd2,
    CLS_XLS       = 3'd3,
    CLS_SBYTE_IMM = 3'd4,
    CLS_UNCOND    = 3'd5
  } cls_e;

  typedef struct packed {
    logic [REG_W-1:0] cond;
    logic [2:0]       top;
    logic [OP1_W-1:0] op1;
    logic [REG_W-1:0] rn;
    logic [REG_W-1:0] rd;
    logic [OP2_W-1:0] op2;
    logic [REG_W-1:0] rm;
  } fields_t;

  function automatic fields_t split_word(input logic [WORD_W-1:0] w);
    fields_t f;
    f.cond = w[31:28];
    f.top  = w[27:25];
    f.op1  = w[24:20];
    f.rn   = w[19:16];
    f.rd   = w[15:12];
    f.op2  = w[7:4];
    f.rm   = w[3:0];
    return f;
  endfunction
endpackage

// File: rtl/a32_grp_split.sv
module a32_grp_split
  import a32_dec_pkg::*;
(
  input  logic [REG_W-1:0] cond_i,
  input  logic [2:0]       top_i,
  output logic             uncond_o,
  output logic             dpm_o
);
  localparam logic [REG_W-1:0] COND_NV = '1;

  assign uncond_o = (cond_i == COND_NV);
  // 00x group: bits 27-26 zero, bit 25 resolved later
  assign dpm_o    = !uncond_o && (top_i[2:1] == 2'b00);
endmodule

// File: rtl/a32_dpm_class.sv
module a32_dpm_class
  import a32_dec_pkg::*;
(
  input  logic             en_i,
  input  logic             imm_i,
  input  logic [OP1_W-1:0] op1_i,
  input  logic [OP2_W-1:0] op2_i,
  output logic             xls_o,
  output logic             dp_reg_o,
  output logic             dp_imm_o
);
  logic misc_op1, unpriv_op1, xls_nib, mul_nib;

  assign misc_op1   = (op1_i[4:3] == 2'b10) && !op1_i[0];
  assign unpriv_op1 = !op1_i[4] && op1_i[1];
  // low nibble is examined ahead of the opcode
  assign xls_nib    = (op2_i == 4'b1011) || ((op2_i[3:2] == 2'b11) && op2_i[0]);
  assign mul_nib    = (op2_i == 4'b1001);

  always_comb begin
    xls_o    = 1'b0;
    dp_reg_o = 1'b0;
    dp_imm_o = 1'b0;
    if (en_i) begin
      if (imm_i) begin
        dp_imm_o = !misc_op1;
      end else if (xls_nib) begin
        xls_o = !unpriv_op1;
      end else if (!mul_nib && !misc_op1) begin
        dp_reg_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/a32_xls_class.sv
module a32_xls_class
  import a32_dec_pkg::*;
(
  input  logic             en_i,
  input  logic [OP1_W-1:0] op1_i,
  input  logic [OP2_W-1:0] op2_i,
  input  logic [REG_W-1:0] rn_i,
  output logic             sbyte_imm_o
);
  localparam logic [REG_W-1:0] PC_REG = '1;

  logic sbyte_nib, imm_load_op1;

  assign sbyte_nib    = (op2_i[2:1] == 2'b10);
  assign imm_load_op1 = op1_i[2] && op1_i[0];
  assign sbyte_imm_o  = en_i && sbyte_nib && imm_load_op1 && (rn_i != PC_REG);
endmodule

// File: rtl/a32_class_decoder.sv
module a32_class_decoder
  import a32_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] instr_i,
  output logic              valid_o,
  output logic [CLS_W-1:0]  class_o,
  output logic              unsup_o,
  output logic [REG_W-1:0]  cond_o,
  output logic [REG_W-1:0]  rn_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [REG_W-1:0]  rm_o,
  output logic              pre_o,
  output logic              up_o,
  output logic              wback_o
);
  fields_t f;
  logic    uncond, dpm, xls, dp_reg, dp_imm, sbyte_imm;
  cls_e    cls_d;
  logic    mem_cls;

  assign f = split_word(instr_i);

  a32_grp_split u_grp (
    .cond_i  (f.cond),
    .top_i   (f.top),
    .uncond_o(uncond),
    .dpm_o   (dpm)
  );

  a32_dpm_class u_dpm (
    .en_i    (dpm),
    .imm_i   (f.top[0]),
    .op1_i   (f.op1),
    .op2_i   (f.op2),
    .xls_o   (xls),
    .dp_reg_o(dp_reg),
    .dp_imm_o(dp_imm)
  );

  a32_xls_class u_xls (
    .en_i       (xls),
    .op1_i      (f.op1),
    .op2_i      (f.op2),
    .rn_i       (f.rn),
    .sbyte_imm_o(sbyte_imm)
  );

  always_comb begin
    if (uncond)         cls_d = CLS_UNCOND;
    else if (sbyte_imm) cls_d = CLS_SBYTE_IMM;
    else if (xls)       cls_d = CLS_XLS;
    else if (dp_imm)    cls_d = CLS_DP_IMM;
    else if (dp_reg)    cls_d = CLS_DP_REG;
    else                cls_d = CLS_UNSUP;
  end

  assign mem_cls = xls;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      class_o <= CLS_UNSUP;
      unsup_o <= 1'b0;
      cond_o  <= '0;
      rn_o    <= '0;
      rd_o    <= '0;
      rm_o    <= '0;
      pre_o   <= 1'b0;
      up_o    <= 1'b0;
      wback_o <= 1'b0;
    end else if (valid_i) begin
      class_o <= cls_d;
      unsup_o <= (cls_d == CLS_UNSUP);
      cond_o  <= f.cond;
      rn_o    <= f.rn;
      rd_o    <= f.rd;
      rm_o    <= f.rm;
      pre_o   <= mem_cls && f.op1[4];
      up_o    <= mem_cls && f.op1[3];
      wback_o <= mem_cls && f.op1[1];
    end
  end
endmodule

// File: rtl/a32_class_decoder_chk.sv
module a32_class_decoder_chk
  import a32_dec_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic [CLS_W-1:0] class_o,
  input logic             unsup_o,
  input logic [REG_W-1:0] cond_o,
  input logic [REG_W-1:0] rn_o,
  input logic [REG_W-1:0] rd_o,
  input logic [REG_W-1:0] rm_o,
  input logic             pre_o,
  input logic             up_o,
  input logic             wback_o
);
  assert_valid_lag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (valid_o == $past(valid_i)));

  assert_unsup_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (unsup_o == (class_o == CLS_UNSUP)));

  assert_nv_class_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cond_o == 4'hF) |-> (class_o == CLS_UNCOND));

  assert_sbyte_rn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (class_o == CLS_SBYTE_IMM) |-> (rn_o != 4'hF));

  assert_flag_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(class_o == CLS_XLS || class_o == CLS_SBYTE_IMM) |-> !(pre_o || up_o || wback_o));

  assert_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(class_o) && $stable(cond_o) && $stable(rn_o)
                  && $stable(rd_o) && $stable(rm_o) && $stable(unsup_o)));
endmodule

bind a32_class_decoder a32_class_decoder_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .valid_o(valid_o),
  .class_o(class_o),
  .unsup_o(unsup_o),
  .cond_o (cond_o),
  .rn_o   (rn_o),
  .rd_o   (rd_o),
  .rm_o   (rm_o),
  .pre_o  (pre_o),
  .up_o   (up_o),
  .wback_o(wback_o)
);

// File: tb/a32_class_decoder_test.sv
`timescale 1ns/1ps
module a32_class_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        valid_o, unsup_o, pre_o, up_o, wback_o;
  logic [2:0]  class_o;
  logic [3:0]  cond_o, rn_o, rd_o, rm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] K_UNSUP = 3'd0, K_DPR = 3'd1, K_DPI = 3'd2,
                         K_XLS = 3'd3, K_SB = 3'd4, K_NV = 3'd5;

  always #2.5 clk_i = ~clk_i;

  a32_class_decoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .valid_o(valid_o), .class_o(class_o), .unsup_o(unsup_o), .cond_o(cond_o),
    .rn_o(rn_o), .rd_o(rd_o), .rm_o(rm_o), .pre_o(pre_o), .up_o(up_o),
    .wback_o(wback_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk_i);
    instr_i = w;
    valid_i = 1'b1;
    @(posedge clk_i);
    #1;
  endtask

  // expected class computed from the requirement text, flags from bits 24/23/21
  task automatic expect_word(input string tag, input logic [31:0] w, input logic [2:0] k);
    logic mem;
    send(w);
    mem = (k == K_XLS) || (k == K_SB);
    chk({tag, " R2 valid"}, valid_o, 1);
    chk({tag, " R3 class"}, class_o, k);
    chk({tag, " R3 unsup"}, unsup_o, k == K_UNSUP);
    chk({tag, " R10 fields"}, {cond_o, rn_o, rd_o, rm_o}, {w[31:28], w[19:16], w[15:12], w[3:0]});
    chk({tag, " R11 flags"}, {pre_o, up_o, wback_o}, mem ? {w[24], w[23], w[21]} : 3'b000);
  endtask

  task automatic t_reset_R1;
    #1;
    chk("R1 valid", valid_o, 0);
    chk("R1 class", class_o, K_UNSUP);
    chk("R1 rest", {unsup_o, cond_o, rn_o, rd_o, rm_o, pre_o, up_o, wback_o}, 0);
  endtask

  task automatic t_target_R12;
    expect_word("R12 E1F120D1", 32'hE1F120D1, K_SB);
    chk("R12 rd", rd_o, 2);
    chk("R12 rn", rn_o, 1);
    chk("R12 puw", {pre_o, up_o, wback_o}, 3'b111);
  endtask

  task automatic t_dp_R9_R6;
    expect_word("R9 mvn reg", 32'hE1E02001, K_DPR);
    expect_word("R9 shifted reg", 32'hE0812312, K_DPR);
    expect_word("R9 cmp reg", 32'hE1510002, K_DPR);
    expect_word("R9 mul", 32'hE0010291, K_UNSUP);
    expect_word("R9 misc bx", 32'hE12FFF1E, K_UNSUP);
    expect_word("R6 mvn imm", 32'hE3E02001, K_DPI);
    expect_word("R6 misc imm", 32'hE3012000, K_UNSUP);
    expect_word("R6 cond 0 imm", 32'h03A0100F, K_DPI);
  endtask

  task automatic t_xls_R7_R8;
    expect_word("R7 ldrh imm", 32'hE1D120B0, K_XLS);
    expect_word("R7 unpriv", 32'hE0F120D1, K_UNSUP);
    expect_word("R8 rn 15", 32'hE15F20D4, K_XLS);
    expect_word("R8 reg offset", 32'hE19120D3, K_XLS);
    expect_word("R8 post idx", 32'hE0D120D1, K_SB);
  endtask

  task automatic t_top_R4_R5;
    expect_word("R4 nv", 32'hF57FF01F, K_NV);
    expect_word("R4 nv looks ldrsb", 32'hF1F120D1, K_NV);
    expect_word("R5 ldr word", 32'hE5912000, K_UNSUP);
    expect_word("R5 branch", 32'hEA000000, K_UNSUP);
  endtask

  task automatic t_hold_R13;
    logic [31:0] snap;
    send(32'hE1F120D1);
    snap = {cond_o, rn_o, rd_o, rm_o, 13'd0, class_o, unsup_o, pre_o, up_o, wback_o, 8'd0};
    @(negedge clk_i);
    valid_i = 1'b0;
    instr_i = 32'hE3E0F00F;
    @(posedge clk_i);
    #1;
    chk("R13 valid low", valid_o, 0);
    chk("R13 hold", {cond_o, rn_o, rd_o, rm_o, 13'd0, class_o, unsup_o, pre_o, up_o, wback_o, 8'd0}, snap);
    @(posedge clk_i);
    #1;
    chk("R13 hold 2", {cond_o, rn_o, rd_o, rm_o, 13'd0, class_o, unsup_o, pre_o, up_o, wback_o, 8'd0}, snap);
  endtask

  task automatic t_latency_R2;
    @(negedge clk_i);
    instr_i = 32'hE3E02001;
    valid_i = 1'b1;
    #1;
    chk("R2 no early change", class_o, K_SB);
    @(posedge clk_i);
    #1;
    chk("R2 after edge", class_o, K_DPI);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset_R1();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_target_R12();
    t_dp_R9_R6();
    t_xls_R7_R8();
    t_top_R4_R5();
    t_hold_R13();
    send(32'hE1F120D1);
    t_latency_R2();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule